// File: doc/BRIEF.md
# Time-Slice Destination Address Selector

This block decides which processing host receives a node's outgoing data. The decision follows a shared absolute time reference. A configuration port loads a small table of IPv4 destination addresses, one per slice. It also loads the number of slices in use, the length of one slice in time-counter ticks, and the absolute time at which slicing begins. Once the free-running time counter reaches that start value, the block steps through the slices in order. It restarts at the first entry after the last one. Every node that shares the time reference and the configuration therefore addresses the same window to the same host, with no messages between nodes.

Packet logic downstream reads four outputs: the current slice index, the registered destination address, an active flag, and a one-cycle boundary strobe. The strobe marks every slice change, so the packet logic can close the packet it is building. A stop command returns the block to idle. The configuration can be changed only while the block is idle.

Top module: `slice_dest_sel`

## Requirements
- R1: After reset the block is idle: `active_o`=0, `slice_idx_o`=0, `dest_addr_o`=0, `boundary_o`=0.
- R2: A configuration write is a one-cycle pulse on `cfg_we_i`. `cfg_kind_i` selects the target: 0 writes the table entry at `cfg_idx_i` from the low 32 bits of `cfg_data_i`, 1 writes the slice count, 2 writes the start time, and 3 writes the slice length (low 24 bits). Writes made while the block is idle take effect.
- R3: A tick is a clock cycle in which `abs_time_i` differs from its value in the previous cycle. The first tick whose time equals the start time starts slicing, provided count and length are both non-zero. In the following cycle the outputs show `active_o`=1, `slice_idx_o`=0, `boundary_o`=1 and `dest_addr_o` equal to entry 0. Before that tick the block stays inactive with address 0.
- R4: While active, the index advances by one after each run of `length` ticks, so slice k begins on the tick whose time is start + k·length. Each advance raises `boundary_o` for exactly one cycle and loads the new slice's table entry into `dest_addr_o`.
- R5: After the slice with index count−1, the next boundary returns the index to 0 and the sequence repeats. This also holds when count is the maximum of 16.
- R6: While active, `dest_addr_o` changes only in a cycle in which `boundary_o` is high.
- R7: While the block is active, writes of all four kinds are ignored. A table entry written during that time keeps its old address once slicing is started again.
- R8: `stop_i` puts the block into the idle state of R1 in the next cycle. Stop takes priority over a boundary that falls in the same cycle.
- R9: A slice count of 0 or a slice length of 0 keeps the block idle when the start time is reached.
- R10: A slice-count write whose data exceeds 16 is ignored, and the previous count is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| abs_time_i | input | 40 | Free-running absolute time counter |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_kind_i | input | 2 | Write target: 0 table entry, 1 count, 2 start time, 3 length |
| cfg_idx_i | input | 4 | Table entry index for kind 0 |
| cfg_data_i | input | 40 | Write data |
| stop_i | input | 1 | Return to idle |
| slice_idx_o | output | 4 | Current slice index |
| dest_addr_o | output | 32 | Selected IPv4 destination address |
| boundary_o | output | 1 | One-cycle slice-change strobe |
| active_o | output | 1 | Slicing is running |

## Verification
The assertions assume three things about the inputs. The time counter only moves forward by one per tick. The start time lies ahead of the current time when the counter runs toward it. Configuration is attempted at any moment, but only idle writes matter. The stimulus honours this: it pauses the time counter while it configures an idle block, and it places every start instant twenty to forty ticks ahead. It also runs the counter both every clock and every third clock, so that ticks are not the same as clock cycles. The scoreboard predicts each boundary from start, length and count alone. It compares the index, the address and the time value present at each strobe.

// File: rtl/slice_pkg.sv
package slice_pkg;

    // Targets of a configuration write
    typedef enum logic [1:0] {
        CFG_ENTRY  = 2'd0,
        CFG_COUNT  = 2'd1,
        CFG_START  = 2'd2,
        CFG_LENGTH = 2'd3
    } cfg_kind_e;

endpackage

// File: rtl/slice_addr_table.sv
module slice_addr_table #(
    parameter int DEPTH  = 16,
    parameter int ADDR_W = 32,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic [IDX_W-1:0]  wr_idx_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  logic [IDX_W-1:0]  rd_idx_i,
    output logic [ADDR_W-1:0] rd_addr_o
);

    logic [ADDR_W-1:0] mem_d [DEPTH];
    logic [ADDR_W-1:0] mem_q [DEPTH];

    always_comb begin
        mem_d = mem_q;
        if (wr_en_i) begin
            mem_d[wr_idx_i] = wr_addr_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_q <= '{default: '0};
        end else begin
            mem_q <= mem_d;
        end
    end

    assign rd_addr_o = mem_q[rd_idx_i];

endmodule

// File: rtl/slice_cfg_regs.sv
module slice_cfg_regs
    import slice_pkg::*;
#(
    parameter int MAX_SLICES = 16,
    parameter int TIME_W     = 40,
    parameter int LEN_W      = 24,
    localparam int CNT_W     = $clog2(MAX_SLICES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lock_i,
    input  logic              wr_en_i,
    input  logic [1:0]        kind_i,
    input  logic [TIME_W-1:0] data_i,
    output logic              tbl_we_o,
    output logic [CNT_W-1:0]  cnt_o,
    output logic [TIME_W-1:0] start_o,
    output logic [LEN_W-1:0]  len_o
);

    typedef struct packed {
        logic [CNT_W-1:0]  cnt;
        logic [TIME_W-1:0] start;
        logic [LEN_W-1:0]  len;
    } cfg_t;

    cfg_t      cfg_d, cfg_q;
    cfg_kind_e kind;
    logic      accept;

    assign kind   = cfg_kind_e'(kind_i);
    assign accept = wr_en_i && !lock_i;

    always_comb begin
        cfg_d    = cfg_q;
        tbl_we_o = 1'b0;
        if (accept) begin
            unique case (kind)
                CFG_ENTRY:  tbl_we_o = 1'b1;
                CFG_COUNT:  begin
                    if (data_i <= TIME_W'(MAX_SLICES)) begin
                        cfg_d.cnt = data_i[CNT_W-1:0];
                    end
                end
                CFG_START:  cfg_d.start = data_i;
                CFG_LENGTH: cfg_d.len   = data_i[LEN_W-1:0];
                default:    ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign cnt_o   = cfg_q.cnt;
    assign start_o = cfg_q.start;
    assign len_o   = cfg_q.len;

    // R7
    locked_cfg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lock_i |=> $stable(cnt_o) && $stable(start_o) && $stable(len_o));

    // R10
    cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_o <= CNT_W'(MAX_SLICES));

endmodule

// File: rtl/slice_sched.sv
module slice_sched #(
    parameter int MAX_SLICES = 16,
    parameter int TIME_W     = 40,
    parameter int LEN_W      = 24,
    localparam int IDX_W     = $clog2(MAX_SLICES),
    localparam int CNT_W     = $clog2(MAX_SLICES + 1),
    localparam int PH_W      = LEN_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [TIME_W-1:0] abs_time_i,
    input  logic [TIME_W-1:0] start_i,
    input  logic [LEN_W-1:0]  len_i,
    input  logic [CNT_W-1:0]  cnt_i,
    input  logic              stop_i,
    output logic              active_o,
    output logic [IDX_W-1:0]  idx_o,
    output logic              strobe_o,
    output logic              load_o,
    output logic [IDX_W-1:0]  next_idx_o
);

    typedef struct packed {
        logic [TIME_W-1:0] prev_time;
        logic [LEN_W-1:0]  phase;
        logic [IDX_W-1:0]  idx;
        logic              active;
        logic              strobe;
    } sched_t;

    sched_t sch_d, sch_q;
    logic   tick;
    logic   armed;
    logic   len_done;
    logic   last_slice;

    assign tick       = (abs_time_i != sch_q.prev_time);
    assign armed      = (abs_time_i == start_i) && (cnt_i != '0) && (len_i != '0);
    assign len_done   = (PH_W'(sch_q.phase) + PH_W'(1)) == PH_W'(len_i);
    assign last_slice = (CNT_W'(sch_q.idx) + CNT_W'(1)) >= cnt_i;

    always_comb begin
        sch_d           = sch_q;
        sch_d.prev_time = abs_time_i;
        sch_d.strobe    = 1'b0;
        if (stop_i) begin
            sch_d.active = 1'b0;
            sch_d.idx    = '0;
            sch_d.phase  = '0;
        end else if (!sch_q.active) begin
            if (tick && armed) begin
                sch_d.active = 1'b1;
                sch_d.idx    = '0;
                sch_d.phase  = '0;
                sch_d.strobe = 1'b1;
            end
        end else if (tick) begin
            if (len_done) begin
                sch_d.phase  = '0;
                sch_d.idx    = last_slice ? '0 : sch_q.idx + IDX_W'(1);
                sch_d.strobe = 1'b1;
            end else begin
                sch_d.phase = sch_q.phase + LEN_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sch_q <= '0;
        end else begin
            sch_q <= sch_d;
        end
    end

    assign active_o   = sch_q.active;
    assign idx_o      = sch_q.idx;
    assign strobe_o   = sch_q.strobe;
    assign load_o     = sch_d.strobe;
    assign next_idx_o = sch_d.idx;

    // R8
    stop_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stop_i |=> !active_o && !strobe_o);

    // R5
    idx_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        active_o |-> CNT_W'(idx_o) < cnt_i);

    // R9
    empty_cfg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_i == '0 || len_i == '0) && !active_o |=> !active_o);

endmodule

// File: rtl/slice_dest_sel.sv
module slice_dest_sel
    import slice_pkg::*;
#(
    parameter int MAX_SLICES = 16,
    parameter int TIME_W     = 40,
    parameter int ADDR_W     = 32,
    parameter int LEN_W      = 24,
    localparam int IDX_W     = $clog2(MAX_SLICES),
    localparam int CNT_W     = $clog2(MAX_SLICES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [TIME_W-1:0] abs_time_i,
    input  logic              cfg_we_i,
    input  logic [1:0]        cfg_kind_i,
    input  logic [IDX_W-1:0]  cfg_idx_i,
    input  logic [TIME_W-1:0] cfg_data_i,
    input  logic              stop_i,
    output logic [IDX_W-1:0]  slice_idx_o,
    output logic [ADDR_W-1:0] dest_addr_o,
    output logic              boundary_o,
    output logic              active_o
);

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
    } out_t;

    logic              tbl_we;
    logic [CNT_W-1:0]  cnt;
    logic [TIME_W-1:0] start_time;
    logic [LEN_W-1:0]  slice_len;
    logic              load;
    logic [IDX_W-1:0]  next_idx;
    logic [ADDR_W-1:0] tbl_addr;
    out_t              out_d, out_q;

    slice_cfg_regs #(
        .MAX_SLICES (MAX_SLICES),
        .TIME_W     (TIME_W),
        .LEN_W      (LEN_W)
    ) u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .lock_i   (active_o),
        .wr_en_i  (cfg_we_i),
        .kind_i   (cfg_kind_i),
        .data_i   (cfg_data_i),
        .tbl_we_o (tbl_we),
        .cnt_o    (cnt),
        .start_o  (start_time),
        .len_o    (slice_len)
    );

    slice_addr_table #(
        .DEPTH  (MAX_SLICES),
        .ADDR_W (ADDR_W)
    ) u_table (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (tbl_we),
        .wr_idx_i  (cfg_idx_i),
        .wr_addr_i (cfg_data_i[ADDR_W-1:0]),
        .rd_idx_i  (next_idx),
        .rd_addr_o (tbl_addr)
    );

    slice_sched #(
        .MAX_SLICES (MAX_SLICES),
        .TIME_W     (TIME_W),
        .LEN_W      (LEN_W)
    ) u_sched (
        .clk        (clk),
        .rst_n      (rst_n),
        .abs_time_i (abs_time_i),
        .start_i    (start_time),
        .len_i      (slice_len),
        .cnt_i      (cnt),
        .stop_i     (stop_i),
        .active_o   (active_o),
        .idx_o      (slice_idx_o),
        .strobe_o   (boundary_o),
        .load_o     (load),
        .next_idx_o (next_idx)
    );

    always_comb begin
        out_d = out_q;
        if (load) begin
            out_d.addr = tbl_addr;
        end else if (stop_i) begin
            out_d.addr = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign dest_addr_o = out_q.addr;

    // R6
    addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        active_o && !boundary_o |-> $stable(dest_addr_o));

    // R1
    idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !active_o |-> slice_idx_o == '0 && dest_addr_o == '0 && !boundary_o);

    // R3
    first_slice_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(active_o) |-> boundary_o && slice_idx_o == '0);

    // R4
    strobe_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
        boundary_o |-> active_o);

endmodule

// File: tb/slice_dest_sel_test.sv
module slice_dest_sel_test;

    localparam int TW = 40;
    localparam int AW = 32;
    localparam int IW = 4;
    localparam int NMAX = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [TW-1:0] abs_time = 40'd7;
    logic          cfg_we = 1'b0;
    logic [1:0]    cfg_kind = 2'd0;
    logic [IW-1:0] cfg_idx = '0;
    logic [TW-1:0] cfg_data = '0;
    logic          stop = 1'b0;
    logic [IW-1:0] slice_idx;
    logic [AW-1:0] dest_addr;
    logic          boundary;
    logic          active;

    always #10 clk = ~clk;

    slice_dest_sel uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .abs_time_i  (abs_time),
        .cfg_we_i    (cfg_we),
        .cfg_kind_i  (cfg_kind),
        .cfg_idx_i   (cfg_idx),
        .cfg_data_i  (cfg_data),
        .stop_i      (stop),
        .slice_idx_o (slice_idx),
        .dest_addr_o (dest_addr),
        .boundary_o  (boundary),
        .active_o    (active)
    );

    int  n_tests = 0;
    int  n_fail  = 0;
    bit  finished = 1'b0;

    typedef struct {
        int unsigned   idx;
        logic [AW-1:0] addr;
        logic [TW-1:0] t;
        string         req;
    } exp_t;

    exp_t          expq[$];
    logic [AW-1:0] tbl [NMAX];
    logic [AW-1:0] cur_addr = '0;

    // time counter model: one step every 'per' clocks while running
    bit run = 1'b0;
    int per = 1;
    int div = 0;
    always @(negedge clk) begin
        if (run) begin
            if (div + 1 >= per) begin
                div = 0;
                abs_time <= abs_time + 40'd1;
            end else begin
                div = div + 1;
            end
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic cfg_write(input logic [1:0] kind, input int idx, input logic [TW-1:0] data);
        @(negedge clk);
        cfg_we   = 1'b1;
        cfg_kind = kind;
        cfg_idx  = IW'(idx);
        cfg_data = data;
        @(negedge clk);
        cfg_we   = 1'b0;
    endtask

    // driver: predict every boundary of a run from start, length and count
    task automatic plan_run(input logic [TW-1:0] s, input int len, input int n, input int k_total);
        for (int k = 0; k < k_total; k++) begin
            exp_t e;
            e.idx  = k % n;
            e.addr = tbl[k % n];
            e.t    = s + TW'(k * len);
            e.req  = (k >= n) ? "R5" : ((k == 0) ? "R3" : "R4");
            expq.push_back(e);
        end
    endtask

    task automatic drain_and_stop();
        while (expq.size() != 0) @(negedge clk);
        stop = 1'b1;
        @(negedge clk);
        stop = 1'b0;
        // R8: idle one cycle after the stop was sampled
        chk(active == 1'b0, "R8", "active after stop", active, 0);
        chk(slice_idx == '0, "R8", "index after stop", slice_idx, 0);
        chk(dest_addr == '0, "R8", "address after stop", dest_addr, 0);
        run = 1'b0;
    endtask

    // monitor: compare each boundary with the scoreboard, hold address between
    always @(posedge clk) begin
        #5;
        if (rst_n && !finished) begin
            if (boundary) begin
                if (expq.size() == 0) begin
                    chk(1'b0, "R4", "unexpected boundary at time", abs_time, 0);
                end else begin
                    exp_t e;
                    e = expq.pop_front();
                    chk(slice_idx == IW'(e.idx), e.req, "slice index", slice_idx, e.idx);
                    // R2: address loaded from the configured table entry
                    chk(dest_addr == e.addr, e.req, "destination", dest_addr, e.addr);
                    chk(abs_time == e.t, e.req, "boundary time", abs_time, e.t);
                    chk(active == 1'b1, e.req, "active at boundary", active, 1);
                    cur_addr = e.addr;
                end
            end else if (active) begin
                chk(dest_addr == cur_addr, "R6", "address inside slice", dest_addr, cur_addr);
            end
        end
    end

    task automatic finish_run();
        finished = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: actual running expected finished");
            finish_run();
        end
    end

    initial begin
        logic [TW-1:0] s;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1
        chk(active == 1'b0, "R1", "active after reset", active, 0);
        chk(slice_idx == '0, "R1", "index after reset", slice_idx, 0);
        chk(dest_addr == '0, "R1", "address after reset", dest_addr, 0);
        chk(boundary == 1'b0, "R1", "boundary after reset", boundary, 0);

        // Run A: 3 slices of 4 ticks, counter steps every clock
        for (int i = 0; i < 3; i++) begin
            tbl[i] = 32'hC0A8_0101 + AW'(i);
            cfg_write(2'd0, i, TW'(tbl[i]));
        end
        cfg_write(2'd1, 0, 40'd3);
        cfg_write(2'd3, 0, 40'd4);
        s = abs_time + 40'd40;
        cfg_write(2'd2, 0, s);
        plan_run(s, 4, 3, 8);
        per = 1; div = 0; run = 1'b1;
        while (abs_time < s - 40'd2) @(negedge clk);
        // R3: not yet active just before the start time
        chk(active == 1'b0, "R3", "active before start", active, 0);
        chk(dest_addr == '0, "R3", "address before start", dest_addr, 0);
        while (expq.size() > 5) @(negedge clk);
        // R7: every kind of write while active is ignored
        cfg_write(2'd0, 0, 40'hDEAD_BEEF);
        cfg_write(2'd1, 0, 40'd1);
        cfg_write(2'd3, 0, 40'd1);
        cfg_write(2'd2, 0, 40'd0);
        drain_and_stop();

        // Run B: count 20 rejected (R10), 2-tick slices, counter every 3 clocks
        cfg_write(2'd1, 0, 40'd20);
        cfg_write(2'd3, 0, 40'd2);
        s = abs_time + 40'd20;
        cfg_write(2'd2, 0, s);
        // entry 0 keeps its pre-run value (R7); count stays 3 (R10)
        plan_run(s, 2, 3, 7);
        per = 3; div = 0; run = 1'b1;
        drain_and_stop();

        // Run C: full 16-entry table, 1-tick slices, wrap at the maximum (R5)
        for (int i = 0; i < NMAX; i++) begin
            tbl[i] = 32'h0A00_0000 + AW'(i * 7 + 1);
            cfg_write(2'd0, i, TW'(tbl[i]));
        end
        cfg_write(2'd1, 0, 40'd16);
        cfg_write(2'd3, 0, 40'd1);
        s = abs_time + 40'd30;
        cfg_write(2'd2, 0, s);
        plan_run(s, 1, 16, 20);
        per = 1; div = 0; run = 1'b1;
        drain_and_stop();

        // R9: count zero keeps the block idle
        cfg_write(2'd1, 0, 40'd0);
        cfg_write(2'd3, 0, 40'd3);
        s = abs_time + 40'd5;
        cfg_write(2'd2, 0, s);
        run = 1'b1;
        while (abs_time < s + 40'd6) @(negedge clk);
        chk(active == 1'b0, "R9", "active with zero count", active, 0);
        chk(dest_addr == '0, "R9", "address with zero count", dest_addr, 0);
        run = 1'b0;

        // R9: length zero keeps the block idle
        cfg_write(2'd1, 0, 40'd2);
        cfg_write(2'd3, 0, 40'd0);
        s = abs_time + 40'd5;
        cfg_write(2'd2, 0, s);
        run = 1'b1;
        while (abs_time < s + 40'd6) @(negedge clk);
        chk(active == 1'b0, "R9", "active with zero length", active, 0);
        run = 1'b0;

        chk(expq.size() == 0, "R4", "boundaries left unseen", expq.size(), 0);
        repeat (2) @(negedge clk);
        finish_run();
    end

endmodule